// File: doc/BRIEF.md
# Burst-of-Two Quad-Rate SRAM Core

This block is an on-chip memory with independent read and write ports. Each port moves a burst of two 18-bit words per K cycle. The block runs from one clock at twice the K rate. An input phase flag tells it which edge is the K-rise half-cycle and which is the K#-rise half-cycle. Read and write commands are sampled only on K-rise half-cycles. The shared address bus carries the read address on the K-rise half and the write address on the K#-rise half. Write data and active-low lane enables arrive once per half-cycle, one word on each.

Each burst address names a word pair, which is held as two consecutive locations of an internal array. A read returns the lower word of the pair first, then the upper word. The two words appear on consecutive half-cycles, starting after the next K-rise edge. A write lands in the array only at the K-rise edge that follows its address half. A read issued in the K cycle right after a write therefore still sees the old pair. The new contents become readable one K cycle later.

Top module: `qb2_sram_core`

## Requirements
- R1: A read starts only when `rd_n` is low at a clock edge where `k_phase` is 1, and the read address is taken from `addr` at that same edge. Low levels on `rd_n` or `wr_n` at edges where `k_phase` is 0 start nothing.
- R2: For a read sampled at K-rise edge E0, `rvalid` is 1 and `rdata` holds the lower word after edge E2, which is the next K-rise edge. After edge E3 they hold the upper word. Reads in consecutive K cycles give a gapless `rvalid`.
- R3: A write starts when `wr_n` is low at a K-rise edge, which captures the lower word and its enables. At the next edge (K# half) the block captures the write address from `addr`, the upper word and its enables.
- R4: Lane enables are active low and are sampled separately for each word. `be_n[0]` governs bits 8:0 and `be_n[1]` governs bits 17:9. A lane whose enable is high keeps its stored value.
- R5: Burst address a maps to word locations 2a (lower word, returned first) and 2a+1 (upper word, returned second).
- R6: A read issued in the K cycle right after a write to the same burst address returns the pre-write contents. A read issued two K cycles after the write returns the new contents.
- R7: A read and a write may both start in the same K cycle without affecting each other. A read in the same K cycle as a write to its address returns the old contents.
- R8: In any half-cycle that carries no read word, `rvalid` is 0 and `rdata` is all zeros.
- R9: Synchronous reset clears `rvalid`, `rdata`, every pending command and the whole array to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the K rate |
| rst | input | 1 | Synchronous active-high reset |
| k_phase | input | 1 | 1 at K-rise half-cycle edges, 0 at K#-rise edges |
| rd_n | input | 1 | Active-low read command (K-rise half only) |
| wr_n | input | 1 | Active-low write command (K-rise half only) |
| addr | input | AW | Read address on K-rise half, write address on K# half |
| wdata | input | 18 | Write word, lower on K-rise half, upper on K# half |
| be_n | input | 2 | Active-low lane enables for the current write word |
| rdata | output | 18 | Read word, zero when idle |
| rvalid | output | 1 | High while rdata carries a read word |

## Verification
The bench overrides AW to 3, which gives eight burst addresses. With so few addresses, random writes and reads hit the same pair within one or two K cycles many times, and this exercises the delayed-visibility and same-cycle cases thoroughly. Directed runs cover the reset image, single-lane and no-lane writes, the read right after a write and the read two cycles after it, and command pulses placed on the K# half. The reference array models the two-cycle visibility rule on its own, separate from the design.

// File: rtl/qb2_pkg.sv
package qb2_pkg;
    localparam int WORD_W = 18;
    localparam int LANE_W = 9;
    localparam int LANES  = WORD_W / LANE_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_en_t;

    // lo is the word returned first (even location)
    typedef struct packed {
        word_t hi;
        word_t lo;
    } pair_t;

    typedef struct packed {
        lane_en_t hi;
        lane_en_t lo;
    } en_pair_t;

    function automatic word_t merge_lanes(word_t cur, word_t nxt, lane_en_t en_n);
        word_t res;
        res = cur;
        for (int l = 0; l < LANES; l++) begin
            if (!en_n[l]) res[l*LANE_W +: LANE_W] = nxt[l*LANE_W +: LANE_W];
        end
        return res;
    endfunction
endpackage

// File: rtl/qb2_write_capture.sv
module qb2_write_capture
    import qb2_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          k_phase,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  word_t         wdata,
    input  lane_en_t      be_n,
    output logic          commit_o,
    output logic [AW-1:0] commit_addr,
    output pair_t         commit_data,
    output en_pair_t      commit_en
);
    logic armed;   // lower word held, waiting for K# half
    logic full;    // whole burst held, waiting for commit edge

    always_ff @(posedge clk) begin
        if (rst) begin
            armed       <= 1'b0;
            full        <= 1'b0;
            commit_addr <= '0;
            commit_data <= '0;
            commit_en   <= '1;
        end else if (k_phase) begin
            full  <= 1'b0;
            armed <= !wr_n;
            if (!wr_n) begin
                commit_data.lo <= wdata;
                commit_en.lo   <= be_n;
            end
        end else begin
            full  <= armed;
            armed <= 1'b0;
            if (armed) begin
                commit_addr    <= addr;
                commit_data.hi <= wdata;
                commit_en.hi   <= be_n;
            end
        end
    end

    // commit at the K-rise edge after the address half
    assign commit_o = full && k_phase;

    assert_commit_follows_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> $past(!wr_n && k_phase, 2));
endmodule

// File: rtl/qb2_storage.sv
module qb2_storage
    import qb2_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr,
    output pair_t         rd_pair,
    input  logic          we,
    input  logic [AW-1:0] wr_addr,
    input  pair_t         wr_data,
    input  en_pair_t      wr_en
);
    localparam int DEPTH = 2 ** (AW + 1);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[{wr_addr, 1'b0}] <= merge_lanes(mem[{wr_addr, 1'b0}], wr_data.lo, wr_en.lo);
            mem[{wr_addr, 1'b1}] <= merge_lanes(mem[{wr_addr, 1'b1}], wr_data.hi, wr_en.hi);
        end
    end

    assign rd_pair.lo = mem[{rd_addr, 1'b0}];
    assign rd_pair.hi = mem[{rd_addr, 1'b1}];

    // R4: a disabled low lane of the lower word survives the commit
    assert_masked_lane_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (we && wr_en.lo[0]) |=>
            mem[{$past(wr_addr), 1'b0}][LANE_W-1:0] == $past(mem[{wr_addr, 1'b0}][LANE_W-1:0]));
endmodule

// File: rtl/qb2_read_pipe.sv
module qb2_read_pipe
    import qb2_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  k_phase,
    input  logic  rd_n,
    input  pair_t rd_pair,
    output word_t rdata,
    output logic  rvalid
);
    logic  pend;     // read sampled, pair held in fetch
    pair_t fetch;
    logic  hi_vld;   // upper word waits for the K# half
    word_t hi_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            fetch   <= '0;
            hi_vld  <= 1'b0;
            hi_hold <= '0;
            rdata   <= '0;
            rvalid  <= 1'b0;
        end else if (k_phase) begin
            rdata   <= pend ? fetch.lo : '0;
            rvalid  <= pend;
            hi_vld  <= pend;
            hi_hold <= fetch.hi;
            pend    <= !rd_n;
            fetch   <= rd_pair;
        end else begin
            rdata   <= hi_vld ? hi_hold : '0;
            rvalid  <= hi_vld;
            hi_vld  <= 1'b0;
        end
    end

    assert_read_first_word_R2: assert property (@(posedge clk) disable iff (rst)
        (k_phase && !rd_n) |=> ##2 rvalid);
    assert_read_second_word_R2: assert property (@(posedge clk) disable iff (rst)
        (k_phase && !rd_n) |=> ##3 rvalid);
    assert_burst_origin_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(rvalid) |-> (!k_phase && $past(!rd_n && k_phase, 3)));
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> (rdata == '0));
endmodule

// File: rtl/qb2_sram_core.sv
module qb2_sram_core
    import qb2_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                k_phase,
    input  logic                rd_n,
    input  logic                wr_n,
    input  logic [AW-1:0]       addr,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [LANES-1:0]    be_n,
    output logic [WORD_W-1:0]   rdata,
    output logic                rvalid
);
    logic          commit;
    logic [AW-1:0] commit_addr;
    pair_t         commit_data;
    en_pair_t      commit_en;
    pair_t         rd_pair;

    qb2_write_capture #(.AW(AW)) u_wcap (
        .clk         (clk),
        .rst         (rst),
        .k_phase     (k_phase),
        .wr_n        (wr_n),
        .addr        (addr),
        .wdata       (wdata),
        .be_n        (be_n),
        .commit_o    (commit),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .commit_en   (commit_en)
    );

    qb2_storage #(.AW(AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (addr),
        .rd_pair (rd_pair),
        .we      (commit),
        .wr_addr (commit_addr),
        .wr_data (commit_data),
        .wr_en   (commit_en)
    );

    qb2_read_pipe u_rpipe (
        .clk     (clk),
        .rst     (rst),
        .k_phase (k_phase),
        .rd_n    (rd_n),
        .rd_pair (rd_pair),
        .rdata   (rdata),
        .rvalid  (rvalid)
    );

    // R9: nothing emerges in the first half-cycle after reset
    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(rst) |-> (!rvalid && rdata == '0));
endmodule

// File: tb/sim_qb2_sram_core.sv
module sim_qb2_sram_core;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;
    localparam int NB = 1 << AW;
    localparam int W  = qb2_pkg::WORD_W;

    logic          clk = 1'b0;
    logic          rst;
    logic          k_phase;
    logic          rd_n, wr_n;
    logic [AW-1:0] addr;
    logic [W-1:0]  wdata;
    logic [1:0]    be_n;
    logic [W-1:0]  rdata;
    logic          rvalid;

    qb2_sram_core #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .k_phase(k_phase), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .be_n(be_n), .rdata(rdata), .rvalid(rvalid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [W-1:0] ref_mem [2*NB];

    // pending writes: older (two K cycles back) and newer (one back)
    logic          po_v, pn_v;
    logic [AW-1:0] po_a, pn_a;
    logic [W-1:0]  po_d0, po_d1, pn_d0, pn_d1;
    logic [1:0]    po_b0, po_b1, pn_b0, pn_b1;

    // expectation for the read issued in the previous K cycle
    logic          e_v;
    logic [W-1:0]  e_w0, e_w1;
    string         e_tag;

    // R4: lane 0 = bits 8:0 by be_n[0], lane 1 = bits 17:9 by be_n[1]
    function automatic logic [W-1:0] mix(logic [W-1:0] cur, logic [W-1:0] nxt, logic [1:0] en_n);
        logic [W-1:0] r = cur;
        if (!en_n[0]) r[8:0]  = nxt[8:0];
        if (!en_n[1]) r[17:9] = nxt[17:9];
        return r;
    endfunction

    task automatic check(string tag, logic xv, logic [W-1:0] xd);
        n_cmp++;
        if (rvalid !== xv || rdata !== xd) begin
            n_bad++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     tag, rvalid, rdata, xv, xd);
        end
    endtask

    // one K cycle; entered and left at a falling edge
    task automatic kcycle(logic rd, logic [AW-1:0] ra, logic wr, logic [AW-1:0] wa,
                          logic [W-1:0] d0, logic [W-1:0] d1, logic [1:0] b0, logic [1:0] b1,
                          string tag, bit junk);
        logic          cv;
        logic [W-1:0]  c0, c1;
        // R6: writes from two or more K cycles back are visible
        if (po_v) begin
            ref_mem[2*po_a]   = mix(ref_mem[2*po_a],   po_d0, po_b0);
            ref_mem[2*po_a+1] = mix(ref_mem[2*po_a+1], po_d1, po_b1);
        end
        // R5: lower word at 2a comes first
        cv = rd;
        c0 = rd ? ref_mem[2*ra]   : '0;
        c1 = rd ? ref_mem[2*ra+1] : '0;
        po_v = pn_v; po_a = pn_a; po_d0 = pn_d0; po_d1 = pn_d1; po_b0 = pn_b0; po_b1 = pn_b1;
        pn_v = wr;   pn_a = wa;   pn_d0 = d0;    pn_d1 = d1;    pn_b0 = b0;    pn_b1 = b1;
        k_phase = 1'b1; rd_n = !rd; wr_n = !wr; addr = ra; wdata = d0; be_n = b0;
        @(negedge clk);
        check(e_tag, e_v, e_v ? e_w0 : '0);
        // R1: command pulses on the K# half must be ignored
        k_phase = 1'b0; addr = wa; wdata = d1; be_n = b1;
        rd_n = junk ? 1'($urandom % 2) : 1'b1;
        wr_n = junk ? 1'($urandom % 2) : 1'b1;
        @(negedge clk);
        check(e_tag, e_v, e_v ? e_w1 : '0);
        e_v = cv; e_w0 = c0; e_w1 = c1; e_tag = tag;
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) kcycle(0, '0, 0, '0, '0, '0, 2'b11, 2'b11, tag, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        for (int i = 0; i < 2*NB; i++) ref_mem[i] = '0;
        po_v = 0; pn_v = 0; po_a = '0; pn_a = '0;
        po_d0 = '0; po_d1 = '0; pn_d0 = '0; pn_d1 = '0;
        po_b0 = '1; po_b1 = '1; pn_b0 = '1; pn_b1 = '1;
        e_v = 0; e_w0 = '0; e_w1 = '0; e_tag = "R8";
        rst = 1'b1; k_phase = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
        addr = '0; wdata = '0; be_n = 2'b11;
        repeat (4) @(negedge clk);
        check("R9", 1'b0, '0);
        rst = 1'b0;

        // R9: array reads back zero after reset
        for (int a = 0; a < NB; a++) kcycle(1, AW'(a), 0, '0, '0, '0, 2'b11, 2'b11, "R9", 0);
        idle("R8", 2);

        // R6: read one cycle after write sees old, two cycles after sees new
        kcycle(0, '0, 1, 3'd5, 18'h2A5A5, 18'h15A5A, 2'b00, 2'b00, "R8", 0);
        kcycle(1, 3'd5, 0, '0, '0, '0, 2'b11, 2'b11, "R6", 0);
        kcycle(1, 3'd5, 0, '0, '0, '0, 2'b11, 2'b11, "R6", 0);
        idle("R8", 1);

        // R4: single-lane and no-lane writes
        kcycle(0, '0, 1, 3'd2, 18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00, "R8", 0);
        kcycle(0, '0, 1, 3'd2, 18'h00000, 18'h00000, 2'b10, 2'b01, "R8", 0);
        kcycle(0, '0, 1, 3'd2, 18'h12345, 18'h12345, 2'b11, 2'b11, "R8", 0);
        idle("R8", 1);
        kcycle(1, 3'd2, 0, '0, '0, '0, 2'b11, 2'b11, "R4", 0);

        // R7: read and write to the same pair in one K cycle
        kcycle(1, 3'd7, 1, 3'd7, 18'h0BEEF, 18'h1CAFE, 2'b00, 2'b00, "R7", 0);
        kcycle(1, 3'd7, 1, 3'd1, 18'h11111, 18'h22222, 2'b00, 2'b00, "R7", 0);
        kcycle(1, 3'd7, 0, '0, '0, '0, 2'b11, 2'b11, "R7", 0);
        idle("R8", 2);

        // R2: back-to-back reads over all pairs; R5 order checked on each
        for (int a = 0; a < NB; a++) kcycle(1, AW'(a), 0, '0, '0, '0, 2'b11, 2'b11, "R2", 0);
        kcycle(1, 3'd4, 0, '0, '0, '0, 2'b11, 2'b11, "R5", 0);
        idle("R8", 2);

        // R3: random traffic with clean K# halves
        for (int i = 0; i < 800; i++)
            kcycle(1'($urandom % 2), AW'($urandom), 1'($urandom % 2), AW'($urandom),
                   W'($urandom), W'($urandom), 2'($urandom), 2'($urandom), "R3", 0);
        // R1: random traffic with stray command pulses on K# halves
        for (int i = 0; i < 800; i++)
            kcycle(1'($urandom % 2), AW'($urandom), 1'($urandom % 2), AW'($urandom),
                   W'($urandom), W'($urandom), 2'($urandom), 2'($urandom), "R1", 1);
        idle("R8", 3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule